// File: doc/BRIEF.md
# Write-Through Store Merge Unit

This unit sits beside a small data-line store and applies processor writes to it. A store request carries a virtual address, a physical address, a size code, write data, an endian select and a hit flag with the line it refers to. When the request hits, the unit reads the word picked by the virtual address and overwrites only the byte lanes the store covers. The lane choice depends on the endian select. The new word goes back into the line, and a dirty flag is raised for the half of the line that holds it.

Every accepted store, whether it hits or misses, is also forwarded to a memory write port. The port is held until memory takes it. A miss never allocates a line and never touches the stored data. The stored words can be loaded directly through a preload port, and any word and the dirty pair of any line can be read out, so line contents can be set up and inspected. A separate clear input drops both dirty flags of one line.

Top module: `wt_store_merge`

## Requirements
- R1: A word store (size code 2) that hits replaces the whole word selected by virtual address bits [4:2] in the given line.
- R2: A halfword store (size code 1) that hits replaces only the 16 bits starting at bit 8*(((big-endian)?2:0) XOR (vaddr & 2)); the other 16 bits keep their old value.
- R3: A byte store (size code 0) that hits replaces only the 8 bits starting at bit 8*(((big-endian)?3:0) XOR (vaddr & 3)).
- R4: A hit with word index 0..3 sets the low dirty flag of its line (rd_dirty bit 0), and a hit with index 4..7 sets the high flag (bit 1), both visible on the clock edge after acceptance.
- R5: Each accepted store raises mem_valid on the edge that accepts it, in the same cycle that a hit's merged word is written.
- R6: A store with the hit flag low changes no stored word and no dirty flag. It still goes to memory.
- R7: The memory request carries size code on mem_size, and on mem_addr carries paddr with bits [1:0] cleared for a word, paddr | (vaddr & 2) for a halfword, and paddr | (vaddr & 3) for a byte. On mem_data it carries the data zero-extended from its low 8, 16 or 32 bits.
- R8: While mem_valid is high and mem_ready is low, mem_addr, mem_data and mem_size hold, st_ready is low, and any store presented then is neither accepted nor applied.
- R9: Dirty flags stay set until clr_valid names their line, which clears both. A hit set in the same cycle wins for its own flag.
- R10: After reset, mem_valid is low, st_ready is high and every dirty flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_vaddr | input | ADDR_W | Virtual address of the store |
| st_paddr | input | ADDR_W | Physical address of the store |
| st_size | input | 2 | 0 byte, 1 halfword, 2 word |
| st_data | input | DATA_W | Store data, right-aligned |
| st_bigend | input | 1 | Big-endian lane selection |
| st_hit | input | 1 | Store hits the given line |
| st_line | input | LINE_W | Line the store refers to |
| clr_valid | input | 1 | Clear dirty flags of one line |
| clr_line | input | LINE_W | Line to clear |
| pre_we | input | 1 | Preload write enable |
| pre_line | input | LINE_W | Preload line |
| pre_word | input | WIDX_W | Preload word index |
| pre_data | input | DATA_W | Preload data |
| rd_line | input | LINE_W | Inspection read line |
| rd_word | input | WIDX_W | Inspection read word index |
| rd_data | output | DATA_W | Stored word at rd_line/rd_word |
| rd_dirty | output | 2 | {high, low} dirty flags of rd_line |
| mem_valid | output | 1 | Memory write request pending |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| mem_size | output | 2 | Memory write size code |

## Verification
The assertions check on every cycle that the memory request is held while it is stalled, that st_ready stays low while a write is pending, and that each accepted store leads to a request. They also check that a hit leaves its half-line dirty flag set and that a miss leaves all dirty flags alone. The bench scenarios are needed for the values themselves. Only they show the merged word for each size, lane and endian choice, the exact memory address and data, the clear-versus-set priority, and that a store offered during a stall leaves the line unchanged.

// File: rtl/wsm_pkg.sv
// Package: shared size encoding and address helpers for the store merge unit.
// Assumes 32-bit words with four byte lanes.
package wsm_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } st_size_e;

    // Memory write address for a given size: low bits come from the virtual address.
    function automatic logic [31:0] wr_addr(input logic [31:0] paddr,
                                            input logic [31:0] vaddr,
                                            input logic [1:0]  size);
        logic [31:0] a;
        case (size)
            SZ_BYTE: a = paddr | {30'd0, vaddr[1:0]};
            SZ_HALF: a = paddr | {30'd0, vaddr[1], 1'b0};
            default: a = {paddr[31:2], 2'b00};
        endcase
        return a;
    endfunction

    // Zero-extend store data to its access width.
    function automatic logic [31:0] wr_data(input logic [31:0] d,
                                            input logic [1:0]  size);
        logic [31:0] r;
        case (size)
            SZ_BYTE: r = {24'd0, d[7:0]};
            SZ_HALF: r = {16'd0, d[15:0]};
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wsm_lane_merge.sv
// Lane merge: overlays a byte, halfword or word store onto an old word.
// Lane offset is the endian-dependent XOR of the low address bits.
// Assumes DATA_W is a multiple of 16 and a power of two.
module wsm_lane_merge
    import wsm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] st_data,
    input  logic [1:0]        st_size,
    input  logic              bigend,
    input  logic [31:0]       vaddr,
    output logic [DATA_W-1:0] new_word
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int SH_W  = OFF_W + 3;

    logic [OFF_W-1:0]  off_byte;
    logic [OFF_W-1:0]  off_half;
    logic [OFF_W-1:0]  off_sel;
    logic [SH_W-1:0]   shamt;
    logic [DATA_W-1:0] mask;

    // Lane offset for each size: byte flips all low bits, halfword keeps lane pairs.
    always_comb begin
        off_byte = {OFF_W{bigend}} ^ vaddr[OFF_W-1:0];
        off_half = {off_byte[OFF_W-1:1], 1'b0};
        case (st_size)
            SZ_BYTE: begin
                off_sel = off_byte;
                mask    = {{(DATA_W-8){1'b0}}, 8'hFF};
            end
            SZ_HALF: begin
                off_sel = off_half;
                mask    = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            end
            default: begin
                off_sel = '0;
                mask    = '1;
            end
        endcase
        shamt = {off_sel, 3'b000};
    end

    // Overlay the shifted store data onto the kept lanes.
    always_comb begin
        new_word = (old_word & ~(mask << shamt)) | ((st_data & mask) << shamt);
    end

endmodule

// File: rtl/wsm_line_store.sv
// Line store: words of each line, per-half dirty flags, preload and inspection ports.
// Assumes WORDS and LINES are powers of two, at least 2.
// A merge write to the same word as a preload in one cycle wins.
module wsm_line_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int LINES  = 4,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic [LINE_W-1:0] pre_line,
    input  logic [WIDX_W-1:0] pre_word,
    input  logic [DATA_W-1:0] pre_data,
    input  logic              mw_en,
    input  logic [LINE_W-1:0] mw_line,
    input  logic [WIDX_W-1:0] mw_word,
    input  logic [DATA_W-1:0] mw_data,
    output logic [DATA_W-1:0] mw_old,
    input  logic              set_en,
    input  logic              set_hi,
    input  logic              clr_en,
    input  logic [LINE_W-1:0] clr_line,
    input  logic [LINE_W-1:0] rd_line,
    input  logic [WIDX_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_dirty,
    output logic [2*LINES-1:0] dirty_all
);
    localparam int DEPTH = LINES * WORDS;

    logic [DATA_W-1:0] words_q [DEPTH];

    // Word array: preload first, merge write overrides.
    always_ff @(posedge clk) begin
        if (pre_we)
            words_q[{pre_line, pre_word}] <= pre_data;
        if (mw_en)
            words_q[{mw_line, mw_word}] <= mw_data;
    end

    // Combinational reads for the merge and for inspection.
    always_comb begin
        mw_old   = words_q[{mw_line, mw_word}];
        rd_data  = words_q[{rd_line, rd_word}];
        rd_dirty = {dirty_all[{rd_line, 1'b1}], dirty_all[{rd_line, 1'b0}]};
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        for (genvar h = 0; h < 2; h++) begin : g_half
            logic flag_q;
            // One dirty flag: set beats clear, sticky otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q <= 1'b0;
                else if (set_en && mw_line == LINE_W'(g) && set_hi == 1'(h))
                    flag_q <= 1'b1;
                else if (clr_en && clr_line == LINE_W'(g))
                    flag_q <= 1'b0;
            end
            assign dirty_all[2*g+h] = flag_q;
        end
    end

endmodule

// File: rtl/wsm_mem_port.sv
// Memory write port: a single holding register with valid/ready handshake.
// Assumes load is only asserted while no request is pending.
module wsm_mem_port #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [1:0]        ld_size,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [1:0]        mem_size
);
    // Request valid: raised on load, dropped when memory takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mem_valid <= 1'b0;
        else if (load)
            mem_valid <= 1'b1;
        else if (mem_ready)
            mem_valid <= 1'b0;
    end

    // Request payload: captured on load, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_data <= '0;
            mem_size <= '0;
        end else if (load) begin
            mem_addr <= ld_addr;
            mem_data <= ld_data;
            mem_size <= ld_size;
        end
    end

endmodule

// File: rtl/wt_store_merge.sv
// Top: accepts one store when the memory port is idle, merges hits into the
// line store, marks the half-line dirty and forwards every store to memory.
// Assumes 32-bit addresses and data; misses never allocate.
module wt_store_merge
    import wsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int LINES  = 4,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_vaddr,
    input  logic [ADDR_W-1:0] st_paddr,
    input  logic [1:0]        st_size,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_bigend,
    input  logic              st_hit,
    input  logic [LINE_W-1:0] st_line,
    input  logic              clr_valid,
    input  logic [LINE_W-1:0] clr_line,
    input  logic              pre_we,
    input  logic [LINE_W-1:0] pre_line,
    input  logic [WIDX_W-1:0] pre_word,
    input  logic [DATA_W-1:0] pre_data,
    input  logic [LINE_W-1:0] rd_line,
    input  logic [WIDX_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_dirty,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [1:0]        mem_size
);
    logic              accept;
    logic              merge_en;
    logic [WIDX_W-1:0] widx;
    logic              upper_half;
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] new_word;
    logic [2*LINES-1:0] dirty_all;

    // Acceptance and word selection.
    always_comb begin
        st_ready   = ~mem_valid;
        accept     = st_valid & st_ready;
        merge_en   = accept & st_hit;
        widx       = st_vaddr[WIDX_W+1:2];
        upper_half = (int'(widx) >= WORDS / 2);
    end

    wsm_lane_merge #(.DATA_W(DATA_W)) u_merge (
        .old_word (old_word),
        .st_data  (st_data),
        .st_size  (st_size),
        .bigend   (st_bigend),
        .vaddr    (st_vaddr),
        .new_word (new_word)
    );

    wsm_line_store #(.DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_we    (pre_we),
        .pre_line  (pre_line),
        .pre_word  (pre_word),
        .pre_data  (pre_data),
        .mw_en     (merge_en),
        .mw_line   (st_line),
        .mw_word   (widx),
        .mw_data   (new_word),
        .mw_old    (old_word),
        .set_en    (merge_en),
        .set_hi    (upper_half),
        .clr_en    (clr_valid),
        .clr_line  (clr_line),
        .rd_line   (rd_line),
        .rd_word   (rd_word),
        .rd_data   (rd_data),
        .rd_dirty  (rd_dirty),
        .dirty_all (dirty_all)
    );

    wsm_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .ld_addr   (wr_addr(st_paddr, st_vaddr, st_size)),
        .ld_data   (wr_data(st_data, st_size)),
        .ld_size   (st_size),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_size  (mem_size)
    );

endmodule

// File: rtl/wt_store_merge_chk.sv
// Checker: protocol and dirty-flag properties, bound to the top module.
module wt_store_merge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int LINES  = 4,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int LINE_W = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic              st_hit,
    input logic [LINE_W-1:0] st_line,
    input logic [ADDR_W-1:0] st_vaddr,
    input logic              clr_valid,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic [1:0]        mem_size,
    input logic [2*LINES-1:0] dirty_all
);
    logic                hit_q;
    logic [LINE_W:0]     flag_idx_q;

    // Remember which dirty flag the last accepted hit must have set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q      <= 1'b0;
            flag_idx_q <= '0;
        end else begin
            hit_q      <= st_valid && st_ready && st_hit;
            flag_idx_q <= {st_line, (int'(st_vaddr[WIDX_W+1:2]) >= WORDS / 2)};
        end
    end

    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !mem_valid && dirty_all == '0);

    a_r5_store_issued: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready |=> mem_valid);

    a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_data) && $stable(mem_size));

    a_r8_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !st_ready);

    a_r4_half_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> dirty_all[flag_idx_q]);

    a_r6_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready && !st_hit && !clr_valid |=> $stable(dirty_all));

endmodule

bind wt_store_merge wt_store_merge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_hit    (st_hit),
    .st_line   (st_line),
    .st_vaddr  (st_vaddr),
    .clr_valid (clr_valid),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_size  (mem_size),
    .dirty_all (dirty_all)
);

// File: tb/test_wt_store_merge.sv
module test_wt_store_merge;
    localparam int LINES = 4;
    localparam int WORDS = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        st_valid;
    logic        st_ready;
    logic [31:0] st_vaddr, st_paddr, st_data;
    logic [1:0]  st_size;
    logic        st_bigend, st_hit;
    logic [1:0]  st_line;
    logic        clr_valid;
    logic [1:0]  clr_line;
    logic        pre_we;
    logic [1:0]  pre_line;
    logic [2:0]  pre_word;
    logic [31:0] pre_data;
    logic [1:0]  rd_line;
    logic [2:0]  rd_word;
    logic [31:0] rd_data;
    logic [1:0]  rd_dirty;
    logic        mem_valid, mem_ready;
    logic [31:0] mem_addr, mem_data;
    logic [1:0]  mem_size;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] m_words [LINES*WORDS];
    logic [1:0]  m_dirty [LINES];

    always #2 clk = ~clk;

    wt_store_merge i_wt_store_merge (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_vaddr(st_vaddr), .st_paddr(st_paddr), .st_size(st_size),
        .st_data(st_data), .st_bigend(st_bigend), .st_hit(st_hit),
        .st_line(st_line), .clr_valid(clr_valid), .clr_line(clr_line),
        .pre_we(pre_we), .pre_line(pre_line), .pre_word(pre_word),
        .pre_data(pre_data), .rd_line(rd_line), .rd_word(rd_word),
        .rd_data(rd_data), .rd_dirty(rd_dirty), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_size(mem_size)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected merged word, computed lane by lane.
    function automatic logic [31:0] exp_merge(input logic [31:0] old, input logic [31:0] d,
                                              input logic [1:0] sz, input logic be,
                                              input logic [31:0] va);
        logic [31:0] r = old;
        int lane;
        if (sz == 2'd2) r = d;
        else if (sz == 2'd1) begin
            lane = va[1] ? 2 : 0;
            if (be) lane = 2 - lane;
            r[lane*8 +: 16] = d[15:0];
        end else begin
            lane = int'(va[1:0]);
            if (be) lane = 3 - lane;
            r[lane*8 +: 8] = d[7:0];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] pa, input logic [31:0] va,
                                             input logic [1:0] sz);
        if (sz == 2'd2) return pa & 32'hFFFF_FFFC;
        if (sz == 2'd1) return pa | (va & 32'h2);
        return pa | (va & 32'h3);
    endfunction

    function automatic logic [31:0] exp_mdata(input logic [31:0] d, input logic [1:0] sz);
        if (sz == 2'd2) return d;
        if (sz == 2'd1) return d & 32'h0000_FFFF;
        return d & 32'h0000_00FF;
    endfunction

    function automatic string size_req(input logic [1:0] sz);
        if (sz == 2'd2) return "R1";
        if (sz == 2'd1) return "R2";
        return "R3";
    endfunction

    task automatic check_dirty_all();
        for (int l = 0; l < LINES; l++) begin
            rd_line = 2'(l);
            #0.5;
            chk("R9 sticky dirty", {30'd0, rd_dirty}, {30'd0, m_dirty[l]});
        end
    endtask

    // One store: drive, check request, optional stall and bogus store, release, check line.
    task automatic do_store(input bit hit, input int line, input logic [31:0] va,
                            input logic [31:0] pa, input logic [1:0] sz,
                            input logic [31:0] d, input bit be, input int waitn,
                            input bit clr, input bit bogus);
        int idx = line * WORDS + int'(va[4:2]);
        logic [31:0] ea = exp_addr(pa, va, sz);
        logic [31:0] ed = exp_mdata(d, sz);
        @(negedge clk);
        st_valid = 1; st_hit = hit; st_line = 2'(line); st_vaddr = va;
        st_paddr = pa; st_size = sz; st_data = d; st_bigend = be;
        clr_valid = clr; clr_line = 2'(line);
        @(negedge clk);
        st_valid = 0; clr_valid = 0;
        if (clr) m_dirty[line] = 2'b00;
        if (hit) begin
            m_words[idx] = exp_merge(m_words[idx], d, sz, be, va);
            m_dirty[line][va[4]] = 1'b1;
        end
        chk("R5 request raised", {31'd0, mem_valid}, 32'd1);
        chk("R7 address", mem_addr, ea);
        chk("R7 data", mem_data, ed);
        chk("R7 size", {30'd0, mem_size}, {30'd0, sz});
        chk("R8 stalled", {31'd0, st_ready}, 32'd0);
        for (int w = 0; w < waitn; w++) begin
            if (bogus && w == 0) begin
                st_valid = 1; st_hit = 1; st_size = 2'd2; st_data = ~d;
                st_paddr = ~pa;
            end
            @(negedge clk);
            st_valid = 0;
            chk("R8 hold valid", {31'd0, mem_valid}, 32'd1);
            chk("R8 hold addr", mem_addr, ea);
            chk("R8 hold data", mem_data, ed);
        end
        mem_ready = 1;
        @(negedge clk);
        mem_ready = 0;
        chk("R8 released", {31'd0, mem_valid}, 32'd0);
        chk("R8 ready again", {31'd0, st_ready}, 32'd1);
        rd_line = 2'(line); rd_word = va[4:2];
        #0.5;
        chk(hit ? size_req(sz) : "R6 miss word", rd_data, m_words[idx]);
        chk(hit ? (clr ? "R9 set wins" : "R4 half dirty") : "R6 miss dirty",
            {30'd0, rd_dirty}, {30'd0, m_dirty[line]});
    endtask

    task automatic do_clear(input int line);
        @(negedge clk);
        clr_valid = 1; clr_line = 2'(line);
        @(negedge clk);
        clr_valid = 0;
        m_dirty[line] = 2'b00;
        rd_line = 2'(line);
        #0.5;
        chk("R9 cleared", {30'd0, rd_dirty}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; st_valid = 0; st_vaddr = 0; st_paddr = 0; st_data = 0;
        st_size = 0; st_bigend = 0; st_hit = 0; st_line = 0; clr_valid = 0;
        clr_line = 0; pre_we = 0; pre_line = 0; pre_word = 0; pre_data = 0;
        rd_line = 0; rd_word = 0; mem_ready = 0;
        for (int l = 0; l < LINES; l++) m_dirty[l] = 2'b00;
        repeat (4) @(negedge clk);
        // Preload every word while reset is held.
        for (int i = 0; i < LINES*WORDS; i++) begin
            pre_we = 1; pre_line = 2'(i / WORDS); pre_word = 3'(i % WORDS);
            pre_data = $urandom; m_words[i] = pre_data;
            @(negedge clk);
        end
        pre_we = 0;
        rst_n = 1;
        @(negedge clk);
        chk("R10 no request", {31'd0, mem_valid}, 32'd0);
        chk("R10 ready", {31'd0, st_ready}, 32'd1);
        for (int l = 0; l < LINES; l++) begin
            rd_line = 2'(l);
            #0.5;
            chk("R10 dirty clear", {30'd0, rd_dirty}, 32'd0);
        end

        // Directed: word store, both endian choices.
        do_store(1, 0, 32'h0000_0004, 32'h8000_0007, 2'd2, 32'hCAFE_F00D, 0, 0, 0, 0);
        do_store(1, 0, 32'h0000_0008, 32'h8000_0008, 2'd2, 32'h1234_5678, 1, 2, 0, 0);
        // Directed: every byte lane, both endian choices.
        for (int b = 0; b < 4; b++) begin
            do_store(1, 1, 32'h0000_0000 | 32'(b), 32'h4000_0010, 2'd0, 32'hFFFF_FF00 | 32'(b + 16'hA0), 0, 1, 0, 0);
            do_store(1, 1, 32'h0000_0004 | 32'(b), 32'h4000_0014, 2'd0, 32'hFFFF_FF00 | 32'(b + 16'hB0), 1, 0, 0, 0);
        end
        // Directed: halfword both halves, both endian choices.
        do_store(1, 2, 32'h0000_0000, 32'h1000_0000, 2'd1, 32'hAAAA_1111, 0, 0, 0, 0);
        do_store(1, 2, 32'h0000_0002, 32'h1000_0000, 2'd1, 32'hAAAA_2222, 0, 0, 0, 0);
        do_store(1, 2, 32'h0000_000C, 32'h1000_0000, 2'd1, 32'hAAAA_3333, 1, 0, 0, 0);
        do_store(1, 2, 32'h0000_000E, 32'h1000_0000, 2'd1, 32'hAAAA_4444, 1, 0, 0, 0);
        // Directed: half-line boundary, index 3 then 4 (R4).
        do_clear(3);
        do_store(1, 3, 32'h0000_000C, 32'h2000_000C, 2'd2, 32'h0303_0303, 0, 0, 0, 0);
        do_store(1, 3, 32'h0000_0010, 32'h2000_0010, 2'd2, 32'h0404_0404, 0, 0, 0, 0);
        // Directed: miss leaves line alone (R6).
        do_clear(1);
        do_store(0, 1, 32'h0000_0014, 32'h3000_0015, 2'd0, 32'h0000_005A, 0, 1, 0, 0);
        // Directed: clear and set same cycle, set wins (R9).
        do_store(1, 0, 32'h0000_001C, 32'h5000_001C, 2'd2, 32'h7777_7777, 0, 0, 1, 0);
        // Directed: store offered during a stall is ignored (R8).
        do_store(1, 2, 32'h0000_0018, 32'h6000_0018, 2'd2, 32'h9999_0000, 0, 3, 0, 1);
        for (int w = 0; w < WORDS; w++) begin
            rd_line = 2'd2; rd_word = 3'(w);
            #0.5;
            chk("R8 ignored store", rd_data, m_words[2*WORDS + w]);
        end
        check_dirty_all();

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            logic [1:0] sz = 2'($urandom_range(0, 2));
            if ($urandom_range(0, 9) == 0) do_clear(int'($urandom_range(0, LINES-1)));
            do_store(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, LINES-1)),
                     $urandom, $urandom, sz, $urandom, bit'($urandom_range(0, 1)),
                     int'($urandom_range(0, 3)), bit'($urandom_range(0, 7) == 0),
                     bit'($urandom_range(0, 3) == 0));
        end
        check_dirty_all();
        for (int i = 0; i < LINES*WORDS; i++) begin
            rd_line = 2'(i / WORDS); rd_word = 3'(i % WORDS);
            #0.5;
            chk("R1 final contents", rd_data, m_words[i]);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule